// File: doc/BRIEF.md
# Dual-Output Compare Waveform Timer

One up-counter drives two pulse outputs, A and B. The counter climbs by one on each selected count tick. When it equals the period compare it returns to zero, so the period compare sets a period that both outputs share. Each output also has its own duty compare (A uses the A-compare, B uses the B-compare). A mode word gives each output an action for three events: its duty-compare match, the period match and a software trigger. Each action is one of none, set, clear or toggle. Normal or inverted polarity, and a fixed 0% or 100% level, come from choosing these actions.

Software writes five registers through a simple write port: the mode word, the two duty compares, the period compare, and a command strobe. The strobe starts the count clock, stops it, or issues a software trigger. The count clock is one of five tick inputs, each an enable pulse from an external prescaler.

Top module: `wavetimer`

## Requirements
- R1: After reset the count is 0, both outputs are 0, the count clock is stopped, and all registers are 0.
- R2: The count rises by one on each counting tick. On a tick where the count equals the period compare, the count becomes 0 instead.
- R3: Mode bits [2:0] choose the tick source. Values 0 to 4 pick that bit of `tick_in`. Values 5 to 7 pick no source, so there is no counting.
- R4: Actions are coded 2'b00 none, 2'b01 set, 2'b10 clear, 2'b11 toggle. Output A takes mode[5:4] on an A-compare match, mode[7:6] on a period match and mode[9:8] on a software trigger. Output B takes mode[11:10] on a B-compare match, mode[13:12] on a period match and mode[15:14] on a software trigger. Matches count only on a counting tick.
- R5: With a duty action of clear and a period action of set (normal polarity), output A is high for A-compare+1 ticks of each period of period-compare+1 ticks. With a duty action of set and a period action of clear (inverted polarity), output B is high for period-compare minus B-compare ticks.
- R6: When a duty match and a period match fall on the same tick, only the period action is applied.
- R7: A command write with bit 2 set is a software trigger. At that edge the count becomes 0 and each output's trigger action is applied. Compare actions in that cycle are discarded.
- R8: When an output's duty action and period action are both none, it keeps the level set by the last software trigger.
- R9: Command bit 0 starts the count clock and bit 1 stops it. If both bits are set, stop wins. While the clock is stopped, the count and both outputs hold.
- R10: When mode bit 3 (waveform mode) is 0, the counter does not count and no compare actions occur.
- R11: The compare registers (address 1 A-compare, 2 B-compare, 3 period) and the mode word (address 0) may be written at any time. A new value is used from the next cycle onward. The command register is at address 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 5 | Count-enable pulses from five clock sources |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 mode, 1 A-compare, 2 B-compare, 3 period, 4 command |
| wr_data | input | WW | Write data |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |
| count | output | CW | Current counter value |
| clk_running | output | 1 | Count clock is enabled |

## Verification
Every result is registered, and each one appears one clock after the rising edge that samples its cause. This covers a tick, a compare match, a register write and a command. A written compare value first affects the match test one cycle after the write. The bench changes inputs on the falling edge. It updates its own model once per rising edge and compares the outputs at the next falling edge, so each expected value lines up with the cycle in which the design's registers change. Directed cases for pulse width, coincident matches, triggers and a stopped clock count output levels over whole periods rather than single cycles.

// File: rtl/wavetimer.sv
module wavetimer #(
  parameter int CW   = 16,
  parameter int NSRC = 5,
  parameter int SELW = 3,
  parameter int WW   = (CW > 16) ? CW : 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] tick_in,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [WW-1:0]   wr_data,
  output logic            out_a,
  output logic            out_b,
  output logic [CW-1:0]   count,
  output logic            clk_running
);
  localparam logic [2:0] A_MODE = 3'd0, A_CMPA = 3'd1, A_CMPB = 3'd2,
                         A_PER = 3'd3, A_CMD = 3'd4;

  logic [15:0]   mode_q;
  logic [CW-1:0] cmpa_q, cmpb_q, per_q, cnt_q;
  logic          run_q, a_q, b_q;
  logic          src, na, nb;

  wire wr_cmd = wr_en && (wr_addr == A_CMD);
  wire swtrg  = wr_cmd && wr_data[2];

  always_comb begin
    src = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (mode_q[SELW-1:0] == SELW'(i)) src = tick_in[i];
  end

  wire tick  = run_q && mode_q[3] && src;
  wire hit_p = tick && (cnt_q == per_q);
  wire hit_a = tick && (cnt_q == cmpa_q);
  wire hit_b = tick && (cnt_q == cmpb_q);

  function automatic logic apply(input logic cur, input logic [1:0] op);
    case (op)
      2'b01:   return 1'b1;
      2'b10:   return 1'b0;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  always_comb begin
    if (swtrg)      na = apply(a_q, mode_q[9:8]);
    else if (hit_p) na = apply(a_q, mode_q[7:6]);
    else if (hit_a) na = apply(a_q, mode_q[5:4]);
    else            na = a_q;
    if (swtrg)      nb = apply(b_q, mode_q[15:14]);
    else if (hit_p) nb = apply(b_q, mode_q[13:12]);
    else if (hit_b) nb = apply(b_q, mode_q[11:10]);
    else            nb = b_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
      per_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      a_q    <= 1'b0;
      b_q    <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_MODE: mode_q <= wr_data[15:0];
          A_CMPA: cmpa_q <= wr_data[CW-1:0];
          A_CMPB: cmpb_q <= wr_data[CW-1:0];
          A_PER:  per_q  <= wr_data[CW-1:0];
          default: ;
        endcase
      end
      if (wr_cmd) begin
        if (wr_data[1])      run_q <= 1'b0;
        else if (wr_data[0]) run_q <= 1'b1;
      end
      if (swtrg)      cnt_q <= '0;
      else if (hit_p) cnt_q <= '0;
      else if (tick)  cnt_q <= cnt_q + 1'b1;
      a_q <= na;
      b_q <= nb;
    end
  end

  assign out_a       = a_q;
  assign out_b       = b_q;
  assign count       = cnt_q;
  assign clk_running = run_q;
endmodule

module wavetimer_chk #(
  parameter int CW = 16,
  parameter int WW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic [WW-1:0] wr_data,
  input logic          out_a,
  input logic          out_b,
  input logic [CW-1:0] count,
  input logic          clk_running,
  input logic          wave
);
  wire cmd = wr_en && (wr_addr == 3'd4);
  wire trg = cmd && wr_data[2];

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count == $past(count) || count == $past(count) + 1'b1 || count == '0)); // R2

  AST_TRIGGER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    trg |=> (count == '0)); // R7

  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_running && !trg) |=> ($stable(count) && $stable(out_a) && $stable(out_b))); // R9

  AST_CLOCK_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd && wr_data[0] && !wr_data[1]) |=> clk_running); // R9

  AST_CLOCK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd && wr_data[1]) |=> !clk_running); // R9

  AST_NO_WAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wave && !trg) |=> $stable(count)); // R10
endmodule

bind wavetimer wavetimer_chk #(.CW(CW), .WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .out_a(out_a), .out_b(out_b), .count(count), .clk_running(clk_running),
  .wave(mode_q[3])
);

// File: tb/tb_wavetimer.sv
`timescale 1ns/1ps
module tb_wavetimer;
  localparam int CW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] tick_in = '0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic out_a, out_b, clk_running;
  logic [CW-1:0] count;

  always #5 clk = ~clk;

  wavetimer dut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .out_a(out_a), .out_b(out_b), .count(count),
    .clk_running(clk_running)
  );

  int tests = 0, fails = 0;
  string tag = "R1";
  logic [15:0] m_mode = '0;
  logic [CW-1:0] m_ca = '0, m_cb = '0, m_per = '0, m_cnt = '0;
  logic m_run = 1'b0, m_a = 1'b0, m_b = 1'b0;

  function automatic logic ap(input logic c, input logic [1:0] op);
    if (op == 2'b01) return 1'b1;
    if (op == 2'b10) return 1'b0;
    if (op == 2'b11) return !c;
    return c;
  endfunction

  task automatic chk(input string t, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [2:0] ad, input logic [15:0] d, input logic [4:0] tk);
    logic sw, src, tick, hp, ha, hb, na, nb, nr;
    logic [CW-1:0] nc;
    wr_en = we; wr_addr = ad; wr_data = d; tick_in = tk;
    sw   = we && ad == 3'd4 && d[2];
    src  = (m_mode[2:0] < 3'd5) ? tk[m_mode[2:0]] : 1'b0;
    tick = m_run && m_mode[3] && src;
    hp = tick && m_cnt == m_per;
    ha = tick && m_cnt == m_ca;
    hb = tick && m_cnt == m_cb;
    na = sw ? ap(m_a, m_mode[9:8])   : hp ? ap(m_a, m_mode[7:6])   : ha ? ap(m_a, m_mode[5:4])   : m_a;
    nb = sw ? ap(m_b, m_mode[15:14]) : hp ? ap(m_b, m_mode[13:12]) : hb ? ap(m_b, m_mode[11:10]) : m_b;
    nc = (sw || hp) ? '0 : tick ? m_cnt + 1'b1 : m_cnt;
    nr = (we && ad == 3'd4) ? (d[1] ? 1'b0 : (d[0] ? 1'b1 : m_run)) : m_run;
    @(posedge clk);
    @(negedge clk);
    if (we && ad == 3'd0) m_mode = d;
    if (we && ad == 3'd1) m_ca = d;
    if (we && ad == 3'd2) m_cb = d;
    if (we && ad == 3'd3) m_per = d;
    m_cnt = nc; m_a = na; m_b = nb; m_run = nr;
    wr_en = 1'b0;
    chk(tag, int'({count, out_a, out_b, clk_running}), int'({m_cnt, m_a, m_b, m_run}));
  endtask

  task automatic wr(input logic [2:0] ad, input logic [15:0] d);
    cyc(1'b1, ad, d, 5'h1f);
  endtask

  task automatic run_hi(input int n, input logic [4:0] tk, output int ha, output int hb);
    ha = 0; hb = 0;
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 3'd0, 16'h0, tk);
      ha += int'(out_a); hb += int'(out_b);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int ha, hb;
    logic [CW-1:0] c0;
    logic a0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 count", int'(count), 0);
    chk("R1 outs", int'({out_a, out_b}), 0);
    chk("R1 running", int'(clk_running), 0);
    rst_n = 1'b1;

    tag = "R5";
    wr(3'd3, 16'd9); wr(3'd1, 16'd3); wr(3'd2, 16'd6);
    wr(3'd0, 16'h0008 | (16'd2 << 4) | (16'd1 << 6) | (16'd2 << 8)
           | (16'd1 << 10) | (16'd2 << 12) | (16'd1 << 14));
    wr(3'd4, 16'h0005);
    run_hi(20, 5'h1f, ha, hb);
    run_hi(10, 5'h1f, ha, hb);
    chk("R5 A high ticks per period", ha, 4);
    chk("R5 B high ticks per period", hb, 3);

    tag = "R3";
    wr(3'd0, 16'h008A | (16'd2 << 4) | (16'd1 << 6) | (16'd1 << 10) | (16'd2 << 12));
    c0 = count;
    run_hi(8, 5'b11011, ha, hb);
    chk("R3 unselected source no count", int'(count), int'(c0));
    wr(3'd0, 16'h008E);
    c0 = count;
    run_hi(8, 5'h1f, ha, hb);
    chk("R3 select 6 no count", int'(count), int'(c0));

    tag = "R6";
    wr(3'd3, 16'd5); wr(3'd1, 16'd5);
    wr(3'd0, 16'h0008 | (16'd2 << 4) | (16'd1 << 6));
    wr(3'd4, 16'h0005);
    run_hi(12, 5'h1f, ha, hb);
    run_hi(12, 5'h1f, ha, hb);
    chk("R6 period action wins", ha, 12);

    tag = "R7";
    wr(3'd3, 16'd20); wr(3'd1, 16'd3);
    wr(3'd0, 16'h0008 | (16'd3 << 4));
    wr(3'd4, 16'h0005);
    run_hi(3, 5'h1f, ha, hb);
    chk("R7 at compare", int'(count), 3);
    a0 = out_a;
    cyc(1'b1, 3'd4, 16'h0004, 5'h1f);
    chk("R7 trigger zeroes count", int'(count), 0);
    chk("R7 compare toggle dropped", int'(out_a), int'(a0));

    tag = "R8";
    wr(3'd0, 16'h0008 | (16'd1 << 8) | (16'd2 << 14));
    wr(3'd4, 16'h0005);
    run_hi(30, 5'h1f, ha, hb);
    chk("R8 A held high", ha, 30);
    chk("R8 B held low", hb, 0);

    tag = "R9";
    wr(3'd4, 16'h0002);
    c0 = count;
    run_hi(10, 5'h1f, ha, hb);
    chk("R9 stopped count holds", int'(count), int'(c0));
    wr(3'd4, 16'h0001);
    chk("R9 start", int'(clk_running), 1);
    wr(3'd4, 16'h0003);
    chk("R9 stop wins", int'(clk_running), 0);
    wr(3'd4, 16'h0001);

    tag = "R10";
    wr(3'd0, 16'h0000);
    c0 = count;
    run_hi(10, 5'h1f, ha, hb);
    chk("R10 no waveform mode no count", int'(count), int'(c0));

    tag = "R4 R2 R11 random";
    wr(3'd3, 16'd11);
    wr(3'd0, 16'h0008 | 16'h5A50);
    wr(3'd4, 16'h0005);
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 4)       cyc(1'b1, 3'd0, 16'($urandom) | ((r < 3) ? 16'h0008 : 16'h0), 5'($urandom));
      else if (r < 9)  cyc(1'b1, 3'd1, 16'($urandom % 14), 5'($urandom));
      else if (r < 14) cyc(1'b1, 3'd2, 16'($urandom % 14), 5'($urandom));
      else if (r < 16) cyc(1'b1, 3'd3, 16'($urandom % 12 + 2), 5'($urandom));
      else if (r < 18) cyc(1'b1, 3'd4, 16'($urandom % 8), 5'($urandom));
      else             cyc(1'b0, 3'd0, 16'h0, 5'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule